// File: doc/BRIEF.md
# Seven-Pin Edge and Level Interrupt Port

This block turns seven external pins into either interrupt sources or plain general purpose pins. For each pin, software picks one of four trigger conditions: low level, rising edge, falling edge or either edge. Software also sets an interrupt enable, a drive direction and an output value. Edge-sensitive pins latch a sticky flag. Software clears the flag by writing a one to its bit. Level-sensitive pins request service for as long as the pin stays low. The per-pin requests go to an interrupt controller.

Raw pin levels pass through a two-stage synchronizer. An edge is found by comparing the newest synchronized sample with the sample before it. When the stop indication is high, the clock is considered gone, so edges are no longer recorded. In that state only a pin in low-level mode can raise its request, and it does so straight from the raw pin level, so the request can act as a wake source. In the other low-power states the port keeps working exactly as it does in run mode.

A simple register write port and a combinational read port give access to six registers: sensitivity, direction, output data, interrupt enable, pin data and edge flags.

Top module: `pin_irq_port`

## Requirements
- R1: After reset, the sensitivity, direction, output data, enable and flag registers read zero, and irq_o, pad_oe_o and pad_out_o are all zero.
- R2: The sensitivity register is at address 0. Pin n uses bits [2n+1:2n], coded 00 low level, 01 rising edge, 10 falling edge, 11 either edge. A matching edge on pin_i[n] sets bit n of the flag register at address 5 on the third rising clock after the pin changes, and not before.
- R3: Writing a one to bit n at address 5 clears flag n. Writing a zero leaves the flag unchanged.
- R4: For an edge-sensitive pin, irq_o[n] equals flag n AND enable bit n. The enable register is at address 3. For a low-level pin, irq_o[n] is high while the synchronized pin is low and enable bit n is set, and that pin never sets its flag.
- R5: Address 4 returns the synchronized level of every pin, two clocks behind pin_i, whatever the pin's direction.
- R6: The direction register (address 1) drives pad_oe_o and the output data register (address 2) drives pad_out_o, each one bit per pin. Both registers read back what was written.
- R7: While stop_i is high, no edge sets a flag. A low-level pin with its enable set drives irq_o[n] from the raw pin_i[n] with no clock edge needed.
- R8: Writes to address 4 have no effect on any register. Addresses 6 and 7 read zero.
- R9: An edge of the non-selected polarity does not set the flag.
- R10: Each pin's configuration affects only that pin's flag and request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 7 | Raw pin levels |
| stop_i | input | 1 | Stop mode: clock treated as absent |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 14 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 14 | Register read data (combinational) |
| irq_o | output | 7 | Per-pin interrupt requests |
| pad_out_o | output | 7 | Output drive values |
| pad_oe_o | output | 7 | Output enables |

## Verification
Each pin is given rising, falling and both-edge patterns. A polarity that does not match, and the cycle just before the flag is due, show whether edge polarity and the sync latency are right. A pin held low in level mode separates level requests from flag-based ones. In stop mode, toggling an edge pin while pulling a level pin low shows that flag capture is off while the raw-pin request path still works. Driving a pin high externally while its output drives low shows that pin data reflects the pin and not the output register.

// File: rtl/pin_irq_port_pkg.sv
package pin_irq_port_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_SENSE = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIR   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_DOUT  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_IEN   = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_PIN   = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_FLAG  = 3'd5;

endpackage

// File: rtl/pip_sync.sv
module pip_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1, s3: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o  = st_q.s2;
    assign prev_o = st_q.s3;

    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev_o == $past(cur_o)) else $error("sync shift broken"); // R5

endmodule

// File: rtl/pip_regs.sv
module pip_regs
    import pin_irq_port_pkg::*;
#(
    parameter int N = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [2*N-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [2*N-1:0]    rd_data_o,
    input  logic [N-1:0]      pin_lvl_i,
    input  logic [N-1:0]      flag_i,
    output logic [2*N-1:0]    sense_o,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      dout_o,
    output logic [N-1:0]      ien_o,
    output logic [N-1:0]      clr_o
);

    localparam int DW = 2 * N;

    typedef struct packed {
        logic [DW-1:0] sense;
        logic [N-1:0]  dir;
        logic [N-1:0]  dout;
        logic [N-1:0]  ien;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        clr_o = '0;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_SENSE: cfg_d.sense = wr_data_i;
                ADDR_DIR:   cfg_d.dir   = wr_data_i[N-1:0];
                ADDR_DOUT:  cfg_d.dout  = wr_data_i[N-1:0];
                ADDR_IEN:   cfg_d.ien   = wr_data_i[N-1:0];
                ADDR_FLAG:  clr_o       = wr_data_i[N-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_SENSE: rd_data_o         = cfg_q.sense;
            ADDR_DIR:   rd_data_o[N-1:0]  = cfg_q.dir;
            ADDR_DOUT:  rd_data_o[N-1:0]  = cfg_q.dout;
            ADDR_IEN:   rd_data_o[N-1:0]  = cfg_q.ien;
            ADDR_PIN:   rd_data_o[N-1:0]  = pin_lvl_i;
            ADDR_FLAG:  rd_data_o[N-1:0]  = flag_i;
            default:    ;
        endcase
    end

    assign sense_o = cfg_q.sense;
    assign dir_o   = cfg_q.dir;
    assign dout_o  = cfg_q.dout;
    assign ien_o   = cfg_q.ien;

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_DIR) |=> dir_o == $past(wr_data_i[N-1:0]))
        else $error("direction write lost"); // R6

    AST_PIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_PIN) |=> $stable(cfg_q))
        else $error("pin data write changed config"); // R8

endmodule

// File: rtl/pip_cell.sv
module pip_cell
    import pin_irq_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_i,
    input  logic [1:0] mode_i,
    input  logic       ien_i,
    input  logic       cur_i,
    input  logic       prev_i,
    input  logic       raw_i,
    input  logic       clr_i,
    output logic       flag_o,
    output logic       irq_o
);

    typedef struct packed {
        logic flag;
    } cell_t;

    cell_t  st_d, st_q;
    sense_e mode;
    logic   rise, fall, hit;

    assign mode = sense_e'(mode_i);
    assign rise = cur_i & ~prev_i;
    assign fall = ~cur_i & prev_i;

    always_comb begin
        case (mode)
            SENSE_RISE: hit = rise;
            SENSE_FALL: hit = fall;
            SENSE_BOTH: hit = rise | fall;
            default:    hit = 1'b0;
        endcase
        if (stop_i) begin
            hit = 1'b0;
        end
        st_d = st_q;
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        if (hit) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (mode == SENSE_LOW) begin
            irq_o = ien_i & (stop_i ? ~raw_i : ~cur_i);
        end else begin
            irq_o = ien_i & st_q.flag;
        end
    end

    assign flag_o = st_q.flag;

    AST_STOP_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !flag_o) |=> !flag_o) else $error("flag set in stop"); // R7

    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LOW && !flag_o) |=> !flag_o) else $error("level pin set flag"); // R4

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_i |-> !irq_o) else $error("request without enable"); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_o) else $error("clear ignored"); // R3

    AST_FLAG_HAS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(cur_i != prev_i)) else $error("flag without edge"); // R2

endmodule

// File: rtl/pin_irq_port.sv
module pin_irq_port
    import pin_irq_port_pkg::*;
#(
    parameter int NUM_PINS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic                  stop_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [2*NUM_PINS-1:0] wr_data_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [2*NUM_PINS-1:0] rd_data_o,
    output logic [NUM_PINS-1:0]   irq_o,
    output logic [NUM_PINS-1:0]   pad_out_o,
    output logic [NUM_PINS-1:0]   pad_oe_o
);

    localparam int DW = 2 * NUM_PINS;

    logic [NUM_PINS-1:0] cur, prev, flags, ien, clr;
    logic [DW-1:0]       sense;

    pip_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    pip_regs #(.N(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .pin_lvl_i (cur),
        .flag_i    (flags),
        .sense_o   (sense),
        .dir_o     (pad_oe_o),
        .dout_o    (pad_out_o),
        .ien_o     (ien),
        .clr_o     (clr)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pip_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .stop_i (stop_i),
            .mode_i (sense[2*g+1:2*g]),
            .ien_i  (ien[g]),
            .cur_i  (cur[g]),
            .prev_i (prev[g]),
            .raw_i  (pin_i[g]),
            .clr_i  (clr[g]),
            .flag_o (flags[g]),
            .irq_o  (irq_o[g])
        );
    end

endmodule

// File: tb/pin_irq_port_tb_top.sv
module pin_irq_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  pin_i = 7'h7F;
    logic        stop_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [13:0] wr_data_i = '0;
    logic [2:0]  rd_addr_i = '0;
    logic [13:0] rd_data_o;
    logic [6:0]  irq_o, pad_out_o, pad_oe_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pin_irq_port dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .stop_i(stop_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
        .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
    );

    task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [13:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [13:0] d);
        rd_addr_i = a;
        #0.5;
        d = rd_data_o;
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pin_i[p] = v;
    endtask

    task automatic t_reset();
        logic [13:0] d;
        for (int a = 0; a < 6; a++) begin
            if (a == 4) continue;
            rd(3'(a), d);
            chk("R1 reg zero", d, 14'h0);
        end
        chk("R1 irq", {7'h0, irq_o}, 14'h0);
        chk("R1 oe/out", {pad_oe_o, pad_out_o}, 14'h0);
    endtask

    task automatic t_regs();
        logic [13:0] d;
        wr(3'd1, 14'h0055);
        wr(3'd2, 14'h002A);
        rd(3'd1, d); chk("R6 dir readback", d, 14'h0055);
        rd(3'd2, d); chk("R6 dout readback", d, 14'h002A);
        chk("R6 pad_oe", {7'h0, pad_oe_o}, 14'h0055);
        chk("R6 pad_out", {7'h0, pad_out_o}, 14'h002A);
        wr(3'd4, 14'h3FFF);
        rd(3'd1, d); chk("R8 dir after pin write", d, 14'h0055);
        rd(3'd0, d); chk("R8 sense after pin write", d, 14'h0);
        rd(3'd3, d); chk("R8 ien after pin write", d, 14'h0);
        rd(3'd6, d); chk("R8 addr6", d, 14'h0);
        rd(3'd7, d); chk("R8 addr7", d, 14'h0);
        wr(3'd1, 14'h0); wr(3'd2, 14'h0);
    endtask

    task automatic t_rise();
        logic [13:0] d;
        set_pin(0, 1'b0); clocks(4);
        rd(3'd5, d); chk("R9 falling ignored on rising pin", d, 14'h0);
        set_pin(0, 1'b1); clocks(2);
        rd(3'd5, d); chk("R2 no flag before third clock", d, 14'h0);
        clocks(1);
        rd(3'd5, d); chk("R2 rising flag", d, 14'h0001);
        chk("R4 edge irq", {7'h0, irq_o}, 14'h0001);
        wr(3'd5, 14'h0000); #1;
        rd(3'd5, d); chk("R3 write zero keeps flag", d, 14'h0001);
        wr(3'd5, 14'h0001); #1;
        rd(3'd5, d); chk("R3 w1c clears", d, 14'h0);
        chk("R3 irq drops", {7'h0, irq_o}, 14'h0);
    endtask

    task automatic t_fall();
        logic [13:0] d;
        set_pin(1, 1'b0); clocks(3);
        rd(3'd5, d); chk("R2 falling flag", d, 14'h0002);
        chk("R4 flag without enable no irq", {7'h0, irq_o}, 14'h0);
        wr(3'd5, 14'h0002);
        set_pin(1, 1'b1); clocks(4);
        rd(3'd5, d); chk("R9 rising ignored on falling pin", d, 14'h0);
    endtask

    task automatic t_both();
        logic [13:0] d;
        set_pin(2, 1'b0); clocks(3);
        rd(3'd5, d); chk("R2 both: fall", d, 14'h0004);
        wr(3'd5, 14'h0004);
        set_pin(2, 1'b1); clocks(3);
        rd(3'd5, d); chk("R2 both: rise", d, 14'h0004);
        wr(3'd5, 14'h0004);
    endtask

    task automatic t_level();
        logic [13:0] d;
        set_pin(3, 1'b0); clocks(1);
        chk("R4 level not before sync", {7'h0, irq_o}, 14'h0);
        clocks(1);
        chk("R4 level irq", {7'h0, irq_o}, 14'h0008);
        rd(3'd5, d); chk("R4 level no flag", d, 14'h0);
        rd(3'd4, d); chk("R5 pin data low", d, 14'h0077);
        set_pin(3, 1'b1); clocks(2);
        chk("R4 level irq released", {7'h0, irq_o}, 14'h0);
    endtask

    task automatic t_pindata();
        logic [13:0] d;
        wr(3'd1, 14'h0020); wr(3'd2, 14'h0000);
        set_pin(5, 1'b1); clocks(2);
        rd(3'd4, d); chk("R5 output pin reads pin level", d, 14'h007F);
        set_pin(6, 1'b0); clocks(1);
        rd(3'd4, d); chk("R5 latency", d, 14'h007F);
        clocks(1);
        rd(3'd4, d); chk("R5 input pin low", d, 14'h003F);
        set_pin(6, 1'b1); clocks(2);
        wr(3'd1, 14'h0);
    endtask

    task automatic t_stop();
        logic [13:0] d;
        // pin4 rising, pin3 level; both enabled
        wr(3'd0, 14'h0100 | 14'h0015 | 14'h0020);
        wr(3'd3, 14'h0018);
        @(negedge clk); stop_i = 1'b1;
        set_pin(4, 1'b0); clocks(3);
        set_pin(4, 1'b1); clocks(4);
        rd(3'd5, d); chk("R7 no flag in stop", d, 14'h0);
        chk("R7 no edge irq in stop", {7'h0, irq_o}, 14'h0);
        @(negedge clk); pin_i[3] = 1'b0; #0.5;
        chk("R7 raw level irq in stop", {7'h0, irq_o}, 14'h0008);
        pin_i[3] = 1'b1; #0.5;
        chk("R7 raw level release", {7'h0, irq_o}, 14'h0);
        stop_i = 1'b0; clocks(3);
        set_pin(4, 1'b0); clocks(3);
        set_pin(4, 1'b1); clocks(3);
        rd(3'd5, d); chk("R10 only pin4 flags", d, 14'h0010);
        chk("R10 only pin4 irq", {7'h0, irq_o}, 14'h0010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        clocks(1);
        t_reset();
        t_regs();
        // pin0 rise, pin1 fall, pin2 both, pin3 level; enable pins 0 and 3
        wr(3'd0, 14'h0031 | 14'h0008);
        wr(3'd3, 14'h0009);
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_pindata();
        t_stop();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule